// File: doc/BRIEF.md
# Configurable Two-Port Synchronous RAM

This block is a shared word store with two fully independent access ports, A and B. Each port has its own clock, synchronous reset, enable, write enable, output-initialise input, address, write data and read data. Either port can read and write any word. Per port, elaboration-time parameters fix the behaviour of the read data during a write, an optional input register stage, an optional extra output register, the value the output is forced to by the initialise input, the access rights of the port, the polarity of each control input and the clock edge used.

A small valid-tracking handshake runs alongside each port. A "new request" input is tagged onto an access. The block returns it on a "result valid" output after exactly the port's read latency. A "ready" output shows whether the port is currently enabled. The handshake never alters what is stored or returned.

Same-address collisions between the ports are not arbitrated. When one port writes a word while the other port accesses it on the same edge, the stored word is correct. The read result of the colliding access is undefined. Contents start at zero.

Top module: `tdp_ram`

## Requirements
- R1: A word written through either port is returned by a later read through either port. Reads with no extra stages appear on the read data right after the edge that samples the address. Two ports reading one address on the same edge both get the stored word. All words hold zero before any write.
- R2: With MODE = 0 (write-first), a write drives the written data onto that port's read data.
- R3: With MODE = 1 (read-first), a write drives the word's previous contents onto that port's read data.
- R4: With MODE = 2 (no-change), a write leaves that port's read data at the last value read.
- R5: IN_REG = 1 adds one edge of latency to reads and delays the write commit by one edge. OUT_REG = 1 adds one further edge. A port's latency is 1 + IN_REG + OUT_REG.
- R6: While a port's enable is inactive and its pipeline is empty, that port writes nothing and its read data keeps its value.
- R7: An active initialise input on an enabled edge loads the port's INIT value into its last output stage on that edge. Stored words are not changed. An initialise input with the enable inactive does nothing.
- R8: When initialise and a read meet at the same output stage on one edge, the INIT value wins. With no extra stages the read result is dropped. With an output register, the read arrives one latency after the request, as usual.
- R9: EN_HIGH, WE_HIGH and INIT_HIGH select active-high (1) or active-low (0) control inputs. CLK_RISE = 0 makes the port act on the falling clock edge.
- R10: The ready output equals the port's enable being active. The result-valid output equals (new request AND enable active), delayed by the port's latency. The new-request input has no effect on data.
- R11: ACC = 1 (read-only) ignores the write enable and treats every access as a read. ACC = 2 (write-only) stores data while its read data stays at INIT. At most one port may be write-only.
- R12: A port in reset drives read data equal to its INIT value and result-valid low.
- R13: A write on one port and an access to the same word by the other port on the same edge leaves the written data stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| en_a | input | 1 | Port A enable (polarity EN_HIGH_A) |
| we_a | input | 1 | Port A write enable (polarity WE_HIGH_A) |
| init_a | input | 1 | Port A output initialise (polarity INIT_HIGH_A) |
| nd_a | input | 1 | Port A new request tag |
| addr_a | input | $clog2(DEPTH) | Port A word address |
| din_a | input | DW | Port A write data |
| dout_a | output | DW | Port A read data |
| rfd_a | output | 1 | Port A ready (enable active) |
| rdy_a | output | 1 | Port A result valid |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| en_b | input | 1 | Port B enable (polarity EN_HIGH_B) |
| we_b | input | 1 | Port B write enable (polarity WE_HIGH_B) |
| init_b | input | 1 | Port B output initialise (polarity INIT_HIGH_B) |
| nd_b | input | 1 | Port B new request tag |
| addr_b | input | $clog2(DEPTH) | Port B word address |
| din_b | input | DW | Port B write data |
| dout_b | output | DW | Port B read data |
| rfd_b | output | 1 | Port B ready (enable active) |
| rdy_b | output | 1 | Port B result valid |

## Verification
The bench builds three instances with 16-bit words and 64 entries. The first pairs a plain active-high write-first port with a read-first port that has both extra stages and active-low enable and write enable. This brings the latency-3 path, the delayed write commit and init racing a read within reach. The second pairs a no-change port with an output register, a falling active edge and an active-low initialise against a plain write-first port, which also hosts the same-address collision. The third pairs a write-only port with a read-only port, so ignored writes and a frozen output can be seen at the ports.

// File: rtl/tdp_ram.sv
module tdp_ram #(
  parameter int DW = 16,
  parameter int DEPTH = 256,
  parameter int MODE_A = 0,
  parameter int IN_REG_A = 0,
  parameter int OUT_REG_A = 0,
  parameter int ACC_A = 0,
  parameter bit EN_HIGH_A = 1'b1,
  parameter bit WE_HIGH_A = 1'b1,
  parameter bit INIT_HIGH_A = 1'b1,
  parameter bit CLK_RISE_A = 1'b1,
  parameter logic [DW-1:0] INIT_A = '0,
  parameter int MODE_B = 0,
  parameter int IN_REG_B = 0,
  parameter int OUT_REG_B = 0,
  parameter int ACC_B = 0,
  parameter bit EN_HIGH_B = 1'b1,
  parameter bit WE_HIGH_B = 1'b1,
  parameter bit INIT_HIGH_B = 1'b1,
  parameter bit CLK_RISE_B = 1'b1,
  parameter logic [DW-1:0] INIT_B = '0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          en_a,
  input  logic          we_a,
  input  logic          init_a,
  input  logic          nd_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] din_a,
  output logic [DW-1:0] dout_a,
  output logic          rfd_a,
  output logic          rdy_a,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          en_b,
  input  logic          we_b,
  input  logic          init_b,
  input  logic          nd_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] din_b,
  output logic [DW-1:0] dout_b,
  output logic          rfd_b,
  output logic          rdy_b
);
  localparam int WR_FIRST = 0;
  localparam int RD_FIRST = 1;
  localparam int NO_CHG   = 2;
  localparam int ACC_RO   = 1;
  localparam int ACC_WO   = 2;
  localparam int LAT_A = 1 + IN_REG_A + OUT_REG_A;
  localparam int LAT_B = 1 + IN_REG_B + OUT_REG_B;

  // R11
  initial wo_pair_chk: assert (!(ACC_A == ACC_WO && ACC_B == ACC_WO));

  // two banks, one per writer; owner bits pick the newest copy of a word
  logic [DW-1:0] mem0 [DEPTH] = '{default: '0};
  logic [DW-1:0] mem1 [DEPTH] = '{default: '0};
  logic          own0 [DEPTH] = '{default: 1'b0};
  logic          own1 [DEPTH] = '{default: 1'b0};

  // ---------------- port A ----------------
  wire ck_a    = CLK_RISE_A ? clk_a : ~clk_a;
  wire en_a_i  = EN_HIGH_A ? en_a : ~en_a;
  wire we_a_i  = (ACC_A == ACC_RO) ? 1'b0 : (WE_HIGH_A ? we_a : ~we_a);
  wire ini_a_i = INIT_HIGH_A ? init_a : ~init_a;
  wire frc_a   = en_a_i & ini_a_i;

  logic          e1_a, w1_a, p1_a;
  logic [AW-1:0] a1_a;
  logic [DW-1:0] d1_a, old_a, nx_a, q1_a;
  logic [LAT_A-1:0] hs_a;

  if (IN_REG_A != 0) begin : g_inreg_a
    always_ff @(posedge ck_a)
      if (rst_a) begin
        e1_a <= 1'b0;
        w1_a <= 1'b0;
      end else begin
        e1_a <= en_a_i;
        w1_a <= we_a_i;
      end
    always_ff @(posedge ck_a) begin
      a1_a <= addr_a;
      d1_a <= din_a;
    end
  end else begin : g_direct_a
    assign e1_a = en_a_i;
    assign w1_a = we_a_i;
    assign a1_a = addr_a;
    assign d1_a = din_a;
  end

  wire hit_a = e1_a & w1_a;
  assign old_a = (own0[a1_a] == own1[a1_a]) ? mem0[a1_a] : mem1[a1_a];

  always_ff @(posedge ck_a)
    if (hit_a) begin
      mem0[a1_a] <= d1_a;
      own0[a1_a] <= own1[a1_a];
    end

  always_comb begin
    if (!w1_a || MODE_A == RD_FIRST) nx_a = old_a;
    else if (MODE_A == NO_CHG)       nx_a = q1_a;
    else                             nx_a = d1_a;
  end

  always_ff @(posedge ck_a)
    if (rst_a) begin
      q1_a <= INIT_A;
      p1_a <= 1'b0;
    end else begin
      p1_a <= e1_a;
      if (OUT_REG_A == 0 && frc_a)        q1_a <= INIT_A;
      else if (e1_a && ACC_A != ACC_WO)   q1_a <= nx_a;
    end

  if (OUT_REG_A != 0) begin : g_outreg_a
    logic [DW-1:0] q2_a;
    always_ff @(posedge ck_a)
      if (rst_a)      q2_a <= INIT_A;
      else if (frc_a) q2_a <= INIT_A;
      else if (p1_a)  q2_a <= q1_a;
    assign dout_a = q2_a;
  end else begin : g_noout_a
    assign dout_a = q1_a;
  end

  always_ff @(posedge ck_a)
    if (rst_a) hs_a <= '0;
    else       hs_a <= LAT_A'({hs_a, nd_a & en_a_i});
  assign rfd_a = en_a_i;
  assign rdy_a = hs_a[LAT_A-1];

  logic [1:0] age_a;
  always_ff @(posedge ck_a)
    if (rst_a)              age_a <= 2'd0;
    else if (age_a != 2'd3) age_a <= age_a + 2'd1;

  // R10
  rdy_lag_a_chk: assert property (@(posedge ck_a) disable iff (rst_a)
    (age_a >= 2'(LAT_A)) |-> (rdy_a == $past(nd_a && en_a_i, LAT_A)));
  // R7
  init_load_a_chk: assert property (@(posedge ck_a) disable iff (rst_a)
    frc_a |=> (dout_a == INIT_A));
  // R6
  idle_hold_a_chk: assert property (@(posedge ck_a) disable iff (rst_a)
    (!en_a_i && !e1_a && !p1_a) |=> $stable(dout_a));
  // R2
  wr_first_a_chk: assert property (@(posedge ck_a) disable iff (rst_a)
    (hit_a && MODE_A == WR_FIRST && OUT_REG_A == 0 && ACC_A == 0 && !frc_a)
      |=> (dout_a == $past(d1_a)));

  // ---------------- port B ----------------
  wire ck_b    = CLK_RISE_B ? clk_b : ~clk_b;
  wire en_b_i  = EN_HIGH_B ? en_b : ~en_b;
  wire we_b_i  = (ACC_B == ACC_RO) ? 1'b0 : (WE_HIGH_B ? we_b : ~we_b);
  wire ini_b_i = INIT_HIGH_B ? init_b : ~init_b;
  wire frc_b   = en_b_i & ini_b_i;

  logic          e1_b, w1_b, p1_b;
  logic [AW-1:0] a1_b;
  logic [DW-1:0] d1_b, old_b, nx_b, q1_b;
  logic [LAT_B-1:0] hs_b;

  if (IN_REG_B != 0) begin : g_inreg_b
    always_ff @(posedge ck_b)
      if (rst_b) begin
        e1_b <= 1'b0;
        w1_b <= 1'b0;
      end else begin
        e1_b <= en_b_i;
        w1_b <= we_b_i;
      end
    always_ff @(posedge ck_b) begin
      a1_b <= addr_b;
      d1_b <= din_b;
    end
  end else begin : g_direct_b
    assign e1_b = en_b_i;
    assign w1_b = we_b_i;
    assign a1_b = addr_b;
    assign d1_b = din_b;
  end

  wire hit_b = e1_b & w1_b;
  assign old_b = (own0[a1_b] == own1[a1_b]) ? mem0[a1_b] : mem1[a1_b];

  always_ff @(posedge ck_b)
    if (hit_b) begin
      mem1[a1_b] <= d1_b;
      own1[a1_b] <= ~own0[a1_b];
    end

  always_comb begin
    if (!w1_b || MODE_B == RD_FIRST) nx_b = old_b;
    else if (MODE_B == NO_CHG)       nx_b = q1_b;
    else                             nx_b = d1_b;
  end

  always_ff @(posedge ck_b)
    if (rst_b) begin
      q1_b <= INIT_B;
      p1_b <= 1'b0;
    end else begin
      p1_b <= e1_b;
      if (OUT_REG_B == 0 && frc_b)        q1_b <= INIT_B;
      else if (e1_b && ACC_B != ACC_WO)   q1_b <= nx_b;
    end

  if (OUT_REG_B != 0) begin : g_outreg_b
    logic [DW-1:0] q2_b;
    always_ff @(posedge ck_b)
      if (rst_b)      q2_b <= INIT_B;
      else if (frc_b) q2_b <= INIT_B;
      else if (p1_b)  q2_b <= q1_b;
    assign dout_b = q2_b;
  end else begin : g_noout_b
    assign dout_b = q1_b;
  end

  always_ff @(posedge ck_b)
    if (rst_b) hs_b <= '0;
    else       hs_b <= LAT_B'({hs_b, nd_b & en_b_i});
  assign rfd_b = en_b_i;
  assign rdy_b = hs_b[LAT_B-1];

  logic [1:0] age_b;
  always_ff @(posedge ck_b)
    if (rst_b)              age_b <= 2'd0;
    else if (age_b != 2'd3) age_b <= age_b + 2'd1;

  // R10
  rdy_lag_b_chk: assert property (@(posedge ck_b) disable iff (rst_b)
    (age_b >= 2'(LAT_B)) |-> (rdy_b == $past(nd_b && en_b_i, LAT_B)));
  // R7
  init_load_b_chk: assert property (@(posedge ck_b) disable iff (rst_b)
    frc_b |=> (dout_b == INIT_B));
  // R6
  idle_hold_b_chk: assert property (@(posedge ck_b) disable iff (rst_b)
    (!en_b_i && !e1_b && !p1_b) |=> $stable(dout_b));
  // R3
  rd_first_b_chk: assert property (@(posedge ck_b) disable iff (rst_b)
    (hit_b && MODE_B == RD_FIRST && OUT_REG_B == 0 && ACC_B == 0 && !frc_b)
      |=> (dout_b == $past(old_b)));
endmodule

// File: tb/test_tdp_ram.sv
`timescale 1ns/1ps
module test_tdp_ram;
  typedef struct {
    int          at;
    int          l;
    bit          k;
    logic [15:0] v;
    string       r;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // lanes: 0/1 first instance A/B, 2/3 second, 4/5 third; controls active high here
  logic        en [6], we [6], ini [6], nd [6];
  logic [5:0]  ad [6];
  logic [15:0] dn [6];
  logic [15:0] dout [6];
  logic        rfd [6], rdy [6];

  int          mode   [6] = '{0, 1, 2, 0, 0, 0};
  int          lat    [6] = '{1, 3, 2, 1, 1, 1};
  bit          outreg [6] = '{0, 1, 1, 0, 0, 0};
  int          acc    [6] = '{0, 0, 0, 0, 2, 1};
  logic [15:0] initv  [6] = '{16'h1234, 16'hBEEF, 16'h0F0F, 16'h0000, 16'h00AA, 16'h0055};
  logic [15:0] lastq  [6];
  logic [15:0] refm   [3][64];
  item_t       sb [$];

  tdp_ram #(.DW(16), .DEPTH(64),
    .MODE_A(0), .INIT_A(16'h1234),
    .MODE_B(1), .IN_REG_B(1), .OUT_REG_B(1), .EN_HIGH_B(1'b0), .WE_HIGH_B(1'b0),
    .INIT_B(16'hBEEF)
  ) i_tdp_ram (
    .clk_a(clk), .rst_a(rst), .en_a(en[0]), .we_a(we[0]), .init_a(ini[0]), .nd_a(nd[0]),
    .addr_a(ad[0]), .din_a(dn[0]), .dout_a(dout[0]), .rfd_a(rfd[0]), .rdy_a(rdy[0]),
    .clk_b(clk), .rst_b(rst), .en_b(~en[1]), .we_b(~we[1]), .init_b(ini[1]), .nd_b(nd[1]),
    .addr_b(ad[1]), .din_b(dn[1]), .dout_b(dout[1]), .rfd_b(rfd[1]), .rdy_b(rdy[1]));

  tdp_ram #(.DW(16), .DEPTH(64),
    .MODE_A(2), .OUT_REG_A(1), .INIT_HIGH_A(1'b0), .CLK_RISE_A(1'b0), .INIT_A(16'h0F0F),
    .MODE_B(0), .INIT_B(16'h0000)
  ) i_tdp_ram_nc (
    .clk_a(~clk), .rst_a(rst), .en_a(en[2]), .we_a(we[2]), .init_a(~ini[2]), .nd_a(nd[2]),
    .addr_a(ad[2]), .din_a(dn[2]), .dout_a(dout[2]), .rfd_a(rfd[2]), .rdy_a(rdy[2]),
    .clk_b(clk), .rst_b(rst), .en_b(en[3]), .we_b(we[3]), .init_b(ini[3]), .nd_b(nd[3]),
    .addr_b(ad[3]), .din_b(dn[3]), .dout_b(dout[3]), .rfd_b(rfd[3]), .rdy_b(rdy[3]));

  tdp_ram #(.DW(16), .DEPTH(64),
    .ACC_A(2), .INIT_A(16'h00AA), .ACC_B(1), .INIT_B(16'h0055)
  ) i_tdp_ram_wr (
    .clk_a(clk), .rst_a(rst), .en_a(en[4]), .we_a(we[4]), .init_a(ini[4]), .nd_a(nd[4]),
    .addr_a(ad[4]), .din_a(dn[4]), .dout_a(dout[4]), .rfd_a(rfd[4]), .rdy_a(rdy[4]),
    .clk_b(clk), .rst_b(rst), .en_b(en[5]), .we_b(we[5]), .init_b(ini[5]), .nd_b(nd[5]),
    .addr_b(ad[5]), .din_b(dn[5]), .dout_b(dout[5]), .rfd_b(rfd[5]), .rdy_b(rdy[5]));

  task automatic check(string r, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h at cycle %0d", r, got, exp, cyc);
    end
  endtask

  task automatic push(int at, int l, bit k, logic [15:0] v, string r);
    item_t it;
    it.at = at; it.l = l; it.k = k; it.v = v; it.r = r;
    sb.push_back(it);
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    for (int j = sb.size() - 1; j >= 0; j--) begin
      if (sb[j].at == cyc) begin
        if (sb[j].k) check(sb[j].r, {15'd0, rdy[sb[j].l]}, sb[j].v);
        else         check(sb[j].r, dout[sb[j].l], sb[j].v);
        sb.delete(j);
      end
    end
  end

  task automatic clear_all();
    for (int l = 0; l < 6; l++) begin
      en[l] = 1'b0; we[l] = 1'b0; ini[l] = 1'b0; nd[l] = 1'b0;
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clear_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // driver: set one lane for the coming edge and queue what it must produce
  task automatic drive(int l, bit w, int a, logic [15:0] d, bit i, bit n, bit x, string r);
    int m = l / 2;
    bit weff = w && (acc[l] != 1);
    logic [15:0] e;
    en[l] = 1'b1; we[l] = w; ad[l] = 6'(a); dn[l] = d; ini[l] = i; nd[l] = n;
    #0.5;
    check("R10 ready", {15'd0, rfd[l]}, 16'd1);
    if (!weff || mode[l] == 1) e = refm[m][a];
    else if (mode[l] == 2)     e = lastq[l];
    else                       e = d;
    if (acc[l] == 2) e = lastq[l];
    if (weff) refm[m][a] = d;
    if (i) begin
      push(cyc + 1, l, 1'b0, initv[l], "R7");
      if (lat[l] > 1 && !w) push(cyc + lat[l], l, 1'b0, e, "R8");
      lastq[l] = outreg[l] ? e : initv[l];
    end else begin
      if (!x) push(cyc + lat[l], l, 1'b0, e, r);
      lastq[l] = x ? 16'hxxxx : e;
    end
    push(cyc + lat[l], l, 1'b1, {15'd0, n}, "R10 valid");
  endtask

  // write attempt with the enable inactive
  task automatic stray(int l, int a, logic [15:0] d);
    en[l] = 1'b0; we[l] = 1'b1; ad[l] = 6'(a); dn[l] = d; nd[l] = 1'b1;
    #0.5;
    check("R10 ready low", {15'd0, rfd[l]}, 16'd0);
    push(cyc + 1, l, 1'b0, lastq[l], "R6 hold");
    push(cyc + 1, l, 1'b1, 16'd0, "R6 no valid");
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: run did not end got=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_all();
    for (int l = 0; l < 6; l++) begin
      ad[l] = '0; dn[l] = '0; lastq[l] = initv[l];
    end
    for (int m = 0; m < 3; m++)
      for (int a = 0; a < 64; a++) refm[m][a] = '0;
    repeat (3) @(negedge clk);
    for (int l = 0; l < 6; l++) begin
      check("R12 reset data", dout[l], initv[l]);
      check("R12 reset valid", {15'd0, rdy[l]}, 16'd0);
    end
    rst = 1'b0;
    idle(3);

    drive(0, 1, 3, 16'h1111, 0, 1, 0, "R2 write-first"); step(); idle(2);
    drive(1, 0, 3, 16'h0000, 0, 1, 0, "R1 cross read latency R5"); step(); idle(4);
    drive(1, 1, 3, 16'h2222, 0, 0, 0, "R3 read-first"); step(); idle(4);
    drive(0, 0, 3, 16'h0000, 0, 1, 0, "R5 delayed commit"); step(); idle(2);
    drive(0, 0, 3, 16'h0000, 0, 1, 0, "R1 same read A");
    drive(1, 0, 3, 16'h0000, 0, 1, 0, "R1 same read B"); step(); idle(4);
    drive(0, 0, 3, 16'h0000, 1, 1, 0, "R8"); step(); idle(2);
    drive(0, 0, 3, 16'h0000, 0, 0, 0, "R7 memory kept"); step(); idle(2);
    stray(0, 7, 16'h7777); step(); idle(2);
    drive(0, 0, 7, 16'h0000, 0, 1, 0, "R6 no write R1 zero"); step(); idle(2);
    drive(1, 0, 3, 16'h0000, 1, 1, 0, "R9 low enable"); step(); idle(4);

    drive(3, 1, 9, 16'h9999, 0, 1, 0, "R2 port B"); step(); idle(2);
    drive(2, 0, 9, 16'h0000, 0, 1, 0, "R9 falling edge R5"); step(); idle(3);
    drive(2, 1, 9, 16'hAAAA, 0, 1, 0, "R4 no-change"); step(); idle(3);
    drive(3, 0, 9, 16'h0000, 0, 0, 0, "R4 stored"); step(); idle(2);
    drive(2, 0, 9, 16'h0000, 1, 1, 0, "R9 low init"); step(); idle(3);
    drive(2, 1, 12, 16'hC0C0, 0, 1, 0, "R13 writer output");
    drive(3, 0, 12, 16'h0000, 0, 1, 1, "R13"); step(); idle(3);
    drive(3, 0, 12, 16'h0000, 0, 1, 0, "R13 stored"); step(); idle(2);

    drive(5, 1, 4, 16'h5555, 0, 1, 0, "R11 read-only"); step(); idle(2);
    drive(4, 1, 4, 16'h4444, 0, 1, 0, "R11 write-only out"); step(); idle(2);
    drive(5, 0, 4, 16'h0000, 0, 1, 0, "R11 write-only stored"); step(); idle(2);
    drive(4, 0, 4, 16'h0000, 0, 0, 0, "R11 write-only read"); step(); idle(2);

    idle(6);
    check("R10 scoreboard drained", 16'(sb.size()), 16'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule